// File: doc/BRIEF.md
# Configuration frame SECDED checker

This block checks one configuration frame as it streams past, one 32-bit word per accepted beat. A frame holds 100 data words followed by one check word. While the words arrive, the block folds each one into a running syndrome and an overall parity bit. When the frame ends it reports one of four outcomes: clean, a single correctable error, an uncorrectable error, or a framing error. The syndrome is rebuilt from zero on every pass, so the same frame can be sent through again after a repair.

For a single error, the block also gives the correction: the index of the word to patch and a one-hot mask of the bit to invert. The word index runs 0..99 for data words, and 100 means the check word. An odd number of upsets (three or more) can alias to a valid-looking single error at a bit that was never hit. The block reports that case as a single error at that location, exactly as the code sees it. Applying that false fix leaves a frame whose syndrome reads clean. The whole-frame CRC that sits downstream is what catches this case.

Control is a two-state machine. ST_COLLECT accepts words. On the check slot with last set, it emits the result and stays in ST_COLLECT. On a last that comes too early, it emits a framing result and stays in ST_COLLECT. On the check slot without last, it emits a framing result and moves to ST_DRAIN. ST_DRAIN discards words until a last arrives, then returns to ST_COLLECT.

Top module: `frame_secded_checker`

## Requirements
- R1: A frame is 100 data words (slots 0..99) followed by a check word (slot 100). In the check word, bits [12:0] hold the 13 Hamming check bits, bit 13 makes the count of ones over the whole frame even, and bits [31:14] are zero.
- R2: Each bit has its own code value. Bit b of data word w has the 13-bit code {w+1 (7 bits), 1'b1, b (5 bits)}. Check word bit j has code 1<<j when j<13, no code when j=13 (it counts only toward parity), and {7'd0, 1'b1, j[4:0]} when j≥14. The syndrome is the XOR of the codes of all set bits. A zero syndrome with even parity reports res_kind 0 (clean) with fix_mask 0.
- R3: A single flipped data bit (w,b) reports res_kind 1 (single), fix_word = w and fix_mask = 1<<b.
- R4: A single flipped check word bit j reports res_kind 1, fix_word = 100 and fix_mask = 1<<j, for every j in 0..31.
- R5: Any two flipped bits report res_kind 2 (uncorrectable) with fix_mask 0.
- R6: Three flipped bits report res_kind 1 or 2. When the result is 1, the location named is none of the flipped bits, and inverting it gives a frame that reports clean. For example, flips at (0,1), (0,2) and (1,0) alias to word 1, bit 3.
- R7: res_valid is a one-cycle pulse on the cycle after the clock edge that accepted the frame's last word. Cycles with in_valid low between words have no effect.
- R8: A last on any slot before 100 reports res_kind 3 (framing) one cycle later. The next word starts a fresh frame that is checked normally.
- R9: A slot-100 word without last reports res_kind 3 one cycle later. All following words up to and including the next last are ignored and give no result. The word after that starts a fresh frame.
- R10: During and after reset, res_valid is low and the block waits for slot 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame word is present this cycle |
| in_last | input | 1 | This word ends the frame |
| in_data | input | 32 | Frame word |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 0 clean, 1 single, 2 uncorrectable, 3 framing |
| fix_word | output | 7 | Word to repair (100 = check word) |
| fix_mask | output | 32 | One-hot bit to invert, zero unless single |

## Verification
The bench targets the boundary slots:
- Word 0 bit 0 and word 99 bit 31. A design with an off-by-one in the word code would send the repair to a neighbouring word.
- Every check word bit, including the parity bit and the reserved bits. A design that mishandled these would either call the error uncorrectable or point into the data words.

It also injects double and triple flips, including a planned alias. A design that confused parity classes would offer a repair for a double. A triple-flip alias that was not reproduced would fail to read clean after the false fix is applied.

Short and long frames are sent with idle gaps, each followed by a good frame. A design that lost its accumulator reset or drain state would either corrupt the next verdict or emit a stray result.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        RES_CLEAN   = 2'd0,
        RES_SINGLE  = 2'd1,
        RES_UNCORR  = 2'd2,
        RES_FRAMING = 2'd3
    } res_kind_e;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_DRAIN   = 1'b1
    } fsm_state_e;

endpackage

// File: rtl/fsc_word_fold.sv
// Syndrome and parity contribution of one frame word.
module fsc_word_fold #(
    parameter int WW = 32,
    parameter int IW = 7,
    parameter int BW = $clog2(WW),
    parameter int SW = IW + 1 + BW
) (
    input  logic [IW-1:0] word_idx,
    input  logic          is_check,
    input  logic [WW-1:0] data,
    output logic [SW-1:0] syn_part,
    output logic          par_part
);

    logic [BW-1:0] low_x;
    logic [IW-1:0] upper;
    logic          odd;
    logic [SW-1:0] chk_syn;
    logic [SW-1:0] rsv_code [WW];

    // per-bit code of the reserved check word bits above the parity bit
    for (genvar j = 0; j < WW; j++) begin : g_rsv
        if (j > SW) begin : g_used
            assign rsv_code[j] = data[j] ? {{IW{1'b0}}, 1'b1, BW'(j)} : '0;
        end else begin : g_none
            assign rsv_code[j] = '0;
        end
    end

    always_comb begin
        low_x = '0;
        for (int b = 0; b < WW; b++) begin
            if (data[b]) low_x = low_x ^ BW'(b);
        end
        odd   = ^data;
        upper = odd ? (word_idx + 1'b1) : '0;
        chk_syn = data[SW-1:0];
        for (int j = 0; j < WW; j++) begin
            chk_syn = chk_syn ^ rsv_code[j];
        end
        syn_part = is_check ? chk_syn : {upper, odd, low_x};
        par_part = odd;
    end

endmodule

// File: rtl/fsc_classify.sv
// Maps final syndrome and parity to an outcome and a repair location.
module fsc_classify
    import fsc_pkg::*;
#(
    parameter int NDATA = 100,
    parameter int WW    = 32,
    parameter int IW    = 7,
    parameter int BW    = $clog2(WW),
    parameter int SW    = IW + 1 + BW
) (
    input  logic [SW-1:0] syn,
    input  logic          par,
    output res_kind_e     kind,
    output logic [IW-1:0] loc_word,
    output logic [WW-1:0] loc_mask
);

    logic [IW-1:0] upper;
    logic          mid;
    logic [BW-1:0] low;

    always_comb begin
        upper    = syn[SW-1:BW+1];
        mid      = syn[BW];
        low      = syn[BW-1:0];
        kind     = RES_UNCORR;
        loc_word = '0;
        loc_mask = '0;
        if (!par) begin
            if (syn == '0) kind = RES_CLEAN;
        end else if (syn == '0) begin
            kind     = RES_SINGLE;
            loc_word = IW'(NDATA);
            loc_mask = WW'(1) << SW;
        end else if ($onehot(syn)) begin
            kind     = RES_SINGLE;
            loc_word = IW'(NDATA);
            loc_mask = WW'(syn);
        end else if (upper == '0 && mid && int'(low) > SW) begin
            kind     = RES_SINGLE;
            loc_word = IW'(NDATA);
            loc_mask = WW'(1) << low;
        end else if (upper != '0 && upper <= IW'(NDATA) && mid) begin
            kind     = RES_SINGLE;
            loc_word = upper - 1'b1;
            loc_mask = WW'(1) << low;
        end
    end

endmodule

// File: rtl/frame_secded_checker.sv
module frame_secded_checker
    import fsc_pkg::*;
#(
    parameter  int NDATA = 100,
    parameter  int WW    = 32,
    localparam int IW    = $clog2(NDATA + 1),
    localparam int BW    = $clog2(WW),
    localparam int SW    = IW + 1 + BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [WW-1:0] in_data,
    output logic          res_valid,
    output logic [1:0]    res_kind,
    output logic [IW-1:0] fix_word,
    output logic [WW-1:0] fix_mask
);

    fsm_state_e    state_q, state_d;
    logic [IW-1:0] cnt_q;
    logic [SW-1:0] syn_q;
    logic          par_q;

    logic          is_check;
    logic [SW-1:0] syn_part, syn_next;
    logic          par_part, par_next;
    res_kind_e     cls_kind, emit_kind;
    logic [IW-1:0] cls_word;
    logic [WW-1:0] cls_mask;
    logic          emit, acc_clear;

    assign is_check = (cnt_q == IW'(NDATA));
    assign syn_next = syn_q ^ syn_part;
    assign par_next = par_q ^ par_part;

    fsc_word_fold #(.WW(WW), .IW(IW), .BW(BW), .SW(SW)) u_fold (
        .word_idx (cnt_q),
        .is_check (is_check),
        .data     (in_data),
        .syn_part (syn_part),
        .par_part (par_part)
    );

    fsc_classify #(.NDATA(NDATA), .WW(WW), .IW(IW), .BW(BW), .SW(SW)) u_cls (
        .syn      (syn_next),
        .par      (par_next),
        .kind     (cls_kind),
        .loc_word (cls_word),
        .loc_mask (cls_mask)
    );

    // next state and frame-end decisions
    always_comb begin
        state_d   = state_q;
        emit      = 1'b0;
        acc_clear = 1'b0;
        emit_kind = RES_FRAMING;
        unique case (state_q)
            ST_COLLECT: begin
                if (in_valid) begin
                    if (is_check) begin
                        emit      = 1'b1;
                        acc_clear = 1'b1;
                        if (in_last) begin
                            emit_kind = cls_kind;
                        end else begin
                            state_d = ST_DRAIN;
                        end
                    end else if (in_last) begin
                        emit      = 1'b1;
                        acc_clear = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (in_valid && in_last) state_d = ST_COLLECT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // accumulator and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            syn_q     <= '0;
            par_q     <= 1'b0;
            res_valid <= 1'b0;
            res_kind  <= '0;
            fix_word  <= '0;
            fix_mask  <= '0;
        end else begin
            if (in_valid && state_q == ST_COLLECT) begin
                if (acc_clear) begin
                    cnt_q <= '0;
                    syn_q <= '0;
                    par_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    syn_q <= syn_next;
                    par_q <= par_next;
                end
            end
            res_valid <= emit;
            if (emit) begin
                res_kind <= emit_kind;
                fix_word <= (emit_kind == RES_SINGLE) ? cls_word : '0;
                fix_mask <= (emit_kind == RES_SINGLE) ? cls_mask : '0;
            end else begin
                res_kind <= '0;
                fix_word <= '0;
                fix_mask <= '0;
            end
        end
    end

    // R1: slot counter never passes the check slot
    a_r1_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= IW'(NDATA));

    // R7: a result only follows an accepted word
    a_r7_result_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));

    // R7: a non-framing verdict only follows a last word
    a_r7_verdict_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != RES_FRAMING) |-> $past(in_last));

    // R9: nothing is reported out of the drain state
    a_r9_drain_silent: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(state_q) == ST_COLLECT));

    // R3: a single verdict names exactly one bit inside the frame
    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == RES_SINGLE) |-> ($onehot(fix_mask) && fix_word <= IW'(NDATA)));

    // R5: uncorrectable verdict carries no repair
    a_r5_no_repair: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == RES_UNCORR) |-> (fix_mask == '0));

endmodule

// File: tb/sim_frame_secded_checker.sv
module sim_frame_secded_checker;
    import fsc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NDATA = 100;
    localparam int NW    = NDATA + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [6:0]  fix_word;
    logic [31:0] fix_mask;

    frame_secded_checker #(.NDATA(NDATA), .WW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .res_valid(res_valid), .res_kind(res_kind),
        .fix_word(fix_word), .fix_mask(fix_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [31:0] frm [NW];
    int ncount = 0;
    int pulses, g_at, last_at, slot100_at, g_word;
    logic [1:0] g_kind;
    logic [31:0] g_mask;
    bit gaps = 1'b0;

    task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] code_of(int w, int b);
        if (w < NDATA)  return {7'(w + 1), 1'b1, 5'(b)};
        else if (b < 13) return 13'(1) << b;
        else if (b == 13) return '0;
        else return {7'd0, 1'b1, 5'(b)};
    endfunction

    task automatic encode();
        logic [12:0] s = '0;
        bit p = 1'b0;
        for (int w = 0; w < NDATA; w++)
            for (int b = 0; b < 32; b++)
                if (frm[w][b]) begin s ^= code_of(w, b); p ^= 1'b1; end
        frm[NDATA] = '0;
        frm[NDATA][12:0] = s;
        frm[NDATA][13] = p ^ (^s);
    endtask

    task automatic new_frame();
        for (int w = 0; w < NDATA; w++) frm[w] = $urandom;
        encode();
    endtask

    task automatic flip(int pos);
        frm[pos / 32][pos % 32] = ~frm[pos / 32][pos % 32];
    endtask

    task automatic sample();
        ncount++;
        if (res_valid) begin
            pulses++;
            g_at = ncount; g_kind = res_kind; g_word = fix_word; g_mask = fix_mask;
        end
    endtask

    task automatic send(int nwords, bit with_last);
        pulses = 0; g_at = -1;
        for (int i = 0; i < nwords; i++) begin
            if (gaps && $urandom_range(0, 3) == 0) begin
                @(negedge clk); sample(); in_valid = 1'b0; in_last = 1'b0;
            end
            @(negedge clk); sample();
            in_valid = 1'b1;
            in_data  = frm[i % NW];
            in_last  = with_last && (i == nwords - 1);
            last_at  = ncount;
            if (i == NW - 1) slot100_at = ncount;
        end
        @(negedge clk); sample(); in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk); sample();
        @(negedge clk); sample();
    endtask

    task automatic run_expect(string req, logic [1:0] kind, int word, logic [31:0] mask);
        send(NW, 1'b1);
        expect_eq(req, "pulses", 32'(pulses), 32'd1);
        expect_eq("R7", "result cycle", 32'(g_at), 32'(last_at + 1));
        expect_eq(req, "kind", 32'(g_kind), 32'(kind));
        expect_eq(req, "word", 32'(g_word), 32'(word));
        expect_eq(req, "mask", g_mask, mask);
    endtask

    function automatic int bit_of(logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic triple(int p1, int p2, int p3);
        int loc;
        new_frame();
        flip(p1); flip(p2); flip(p3);
        send(NW, 1'b1);
        expect_eq("R6", "pulses", 32'(pulses), 32'd1);
        checks++;
        if (g_kind != 2'd1 && g_kind != 2'd2) begin
            errors++;
            $display("FAIL R6 kind actual=%0d expected=1or2", g_kind);
        end
        if (g_kind == 2'd1) begin
            loc = g_word * 32 + bit_of(g_mask);
            checks++;
            if (loc == p1 || loc == p2 || loc == p3) begin
                errors++;
                $display("FAIL R6 alias location actual=%0d expected=not %0d/%0d/%0d", loc, p1, p2, p3);
            end
            flip(loc);
            run_expect("R6", 2'd0, 0, '0);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int p1, p2, p3;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        expect_eq("R10", "res_valid in reset", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R10", "res_valid after reset", 32'(res_valid), 32'd0);

        // R2 clean frames, with and without gaps (R7)
        for (int k = 0; k < 6; k++) begin
            gaps = k[0];
            new_frame();
            run_expect("R2", 2'd0, 0, '0);
        end
        for (int w = 0; w < NDATA; w++) frm[w] = '0;
        encode();
        run_expect("R2", 2'd0, 0, '0);

        // R3 single data flips: corners then random
        new_frame(); flip(0);            run_expect("R3", 2'd1, 0, 32'h1);
        new_frame(); flip(99 * 32 + 31); run_expect("R3", 2'd1, 99, 32'h8000_0000);
        for (int k = 0; k < 20; k++) begin
            gaps = (k % 3 == 0);
            p1 = $urandom_range(0, NDATA * 32 - 1);
            new_frame(); flip(p1);
            run_expect("R3", 2'd1, p1 / 32, 32'(1) << (p1 % 32));
        end
        gaps = 1'b0;

        // R4 every check word bit
        for (int j = 0; j < 32; j++) begin
            new_frame(); flip(NDATA * 32 + j);
            run_expect("R4", 2'd1, NDATA, 32'(1) << j);
        end

        // R5 double flips: same word, data+check, random
        new_frame(); flip(5 * 32 + 3); flip(5 * 32 + 17); run_expect("R5", 2'd2, 0, '0);
        new_frame(); flip(7); flip(NDATA * 32 + 13);       run_expect("R5", 2'd2, 0, '0);
        for (int k = 0; k < 20; k++) begin
            p1 = $urandom_range(0, NW * 32 - 1);
            do p2 = $urandom_range(0, NW * 32 - 1); while (p2 == p1);
            new_frame(); flip(p1); flip(p2);
            run_expect("R5", 2'd2, 0, '0);
        end

        // R6 planned alias: (0,1),(0,2),(1,0) -> word 1 bit 3
        new_frame(); flip(1); flip(2); flip(32);
        run_expect("R6", 2'd1, 1, 32'h8);
        flip(32 + 3);
        run_expect("R6", 2'd0, 0, '0);
        for (int k = 0; k < 20; k++) begin
            p1 = $urandom_range(0, NW * 32 - 1);
            do p2 = $urandom_range(0, NW * 32 - 1); while (p2 == p1);
            do p3 = $urandom_range(0, NW * 32 - 1); while (p3 == p1 || p3 == p2);
            triple(p1, p2, p3);
        end

        // R8 early last, then a normal frame
        new_frame();
        send(50, 1'b1);
        expect_eq("R8", "pulses", 32'(pulses), 32'd1);
        expect_eq("R8", "kind", 32'(g_kind), 32'd3);
        expect_eq("R8", "result cycle", 32'(g_at), 32'(last_at + 1));
        send(1, 1'b1);
        expect_eq("R8", "single word kind", 32'(g_kind), 32'd3);
        new_frame(); flip(40 * 32 + 9);
        run_expect("R8", 2'd1, 40, 32'h200);

        // R9 long frame, drain, then normal frame
        gaps = 1'b1;
        new_frame();
        send(NW + 6, 1'b1);
        expect_eq("R9", "pulses", 32'(pulses), 32'd1);
        expect_eq("R9", "kind", 32'(g_kind), 32'd3);
        expect_eq("R9", "result cycle", 32'(g_at), 32'(slot100_at + 1));
        new_frame(); flip(NDATA * 32 + 2);
        run_expect("R9", 2'd1, NDATA, 32'h4);
        new_frame();
        run_expect("R9", 2'd0, 0, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule